// File: doc/BRIEF.md
# I2C Byte Slave with Clock Hold

This block is the target side of an I2C bus. It answers a 7-bit address and moves one byte at a time. After the acknowledge slot of every byte it addresses or carries, it holds SCL low. It keeps holding until the host side services its data register, so software can take as long as it needs between bytes. Both bus lines are open-drain: the block reads each line and has a separate output that pulls it low.

The host side is a small register interface. The host can write and read the data register. It supplies two control levels: transmit mode and "withhold acknowledge". It reads back four status outputs: address matched, the latched direction bit, the acknowledge bit received from the master, and a one-cycle byte-done pulse.

Software picks the direction from the latched direction bit.
- For a master read, it sets transmit mode and writes the first byte. That write releases the bus.
- For a master write, it clears transmit mode and does a dummy read. That read releases the bus.
- When the master declines a transmitted byte, software returns to receive mode and does a dummy read. This frees the bus for the master's STOP.

Top module: `i2c_hold_slave`

## Requirements
- R1: After a START, the slave shifts in 8 bits MSB first on SCL rising edges. If the first 7 bits equal OWN_ADDR, st_match goes to 1 and the 8th bit is latched into st_rw (1 = master reads).
- R2: A non-matching address gets no acknowledge. It also causes no SCL hold and no byte_irq, and st_match stays 0.
- R3: During the acknowledge slot of every byte the slave receives, including the address byte, sda_low_o is asserted when ctl_txak is 0 and stays deasserted when ctl_txak is 1.
- R4: On the SCL falling edge that ends an acknowledge slot, byte_irq pulses for exactly one clock and scl_low_o rises in the same cycle. scl_low_o then stays asserted until a releasing host access.
- R5: With ctl_tx = 0, a host_rd pulse releases the hold and the next byte is received. A host_wr pulse does not release it.
- R6: With ctl_tx = 1, a host_wr pulse loads host_wdata, releases the hold, and the byte is shifted out MSB first. A host_rd pulse does not release it.
- R7: host_rdata shows the last received byte, MSB first.
- R8: In the acknowledge slot of a transmitted byte, the SDA level at the SCL rising edge is latched into st_rxak (0 = acknowledged, 1 = declined).
- R9: A STOP clears st_match and returns the slave to idle with both lines released. No byte_irq is raised for it.
- R10: sda_low_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pulls SCL low (clock hold) |
| sda_low_o | output | 1 | Pulls SDA low |
| host_wr | input | 1 | Data register write strobe |
| host_rd | input | 1 | Data register read strobe |
| host_wdata | input | 8 | Data written to the data register |
| host_rdata | output | 8 | Data register contents |
| ctl_tx | input | 1 | Transmit mode (1) or receive mode (0) |
| ctl_txak | input | 1 | 1 withholds the acknowledge on received bytes |
| st_match | output | 1 | Address matched in the current transfer |
| st_rw | output | 1 | Latched direction bit |
| st_rxak | output | 1 | Acknowledge bit received from the master |
| byte_irq | output | 1 | One-cycle byte-done pulse |

## Verification
The assertions depend on a well-behaved master:
- It issues START and STOP only while the slave is not holding SCL and not driving SDA.
- It keeps each SCL level for several clocks longer than the input synchronizer delay.
- It makes host accesses only while the hold is active.

The bench master drives every bit with phases of eight clocks. It waits for SCL to read high before it counts the high phase. It issues its STOP only after software has released the final hold, so no protocol event ever arrives while the slave owns a line.

// File: rtl/i2c_hold_slave.sv
module i2c_hold_slave #(
  parameter logic [6:0] OWN_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       ctl_tx,
  input  logic       ctl_txak,
  output logic       st_match,
  output logic       st_rw,
  output logic       st_rxak,
  output logic       byte_irq
);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_ACK, S_HOLD} phase_t;

  logic [SYNC_STAGES:0] scl_sr, sda_sr;
  logic       s_scl, p_scl, s_sda, p_sda;
  logic       scl_rise, scl_fall, start_c, stop_c;
  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       addr_ph, xmit, hold, sda_drv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_i};
    end

  assign s_scl    = scl_sr[SYNC_STAGES-1];
  assign p_scl    = scl_sr[SYNC_STAGES];
  assign s_sda    = sda_sr[SYNC_STAGES-1];
  assign p_sda    = sda_sr[SYNC_STAGES];
  assign scl_rise = s_scl & ~p_scl;
  assign scl_fall = ~s_scl & p_scl;
  assign start_c  = s_scl & p_scl & p_sda & ~s_sda;
  assign stop_c   = s_scl & p_scl & ~p_sda & s_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      cnt      <= '0;
      sh       <= '0;
      addr_ph  <= 1'b0;
      xmit     <= 1'b0;
      hold     <= 1'b0;
      sda_drv  <= 1'b0;
      st_match <= 1'b0;
      st_rw    <= 1'b0;
      st_rxak  <= 1'b0;
      byte_irq <= 1'b0;
    end else begin
      byte_irq <= 1'b0;
      if (start_c) begin
        phase    <= S_BITS;
        cnt      <= '0;
        addr_ph  <= 1'b1;
        xmit     <= 1'b0;
        hold     <= 1'b0;
        sda_drv  <= 1'b0;
        st_match <= 1'b0;
      end else if (stop_c) begin
        phase    <= S_IDLE;
        hold     <= 1'b0;
        sda_drv  <= 1'b0;
        st_match <= 1'b0;
      end else begin
        case (phase)
          S_BITS: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
              if (!xmit) sh <= {sh[6:0], s_sda};
            end else if (scl_fall && cnt == 4'd8) begin
              if (xmit) begin
                sda_drv <= 1'b0;
                phase   <= S_ACK;
              end else if (addr_ph && sh[7:1] != OWN_ADDR) begin
                phase <= S_IDLE;
              end else begin
                if (addr_ph) begin
                  st_match <= 1'b1;
                  st_rw    <= sh[0];
                end
                sda_drv <= ~ctl_txak;
                phase   <= S_ACK;
              end
            end else if (scl_fall && xmit) begin
              sda_drv <= ~sh[6];
              sh      <= {sh[6:0], 1'b0};
            end
          end
          S_ACK: begin
            if (scl_rise && xmit) begin
              st_rxak <= s_sda;
            end else if (scl_fall) begin
              sda_drv  <= 1'b0;
              hold     <= 1'b1;
              byte_irq <= 1'b1;
              phase    <= S_HOLD;
            end
          end
          S_HOLD: begin
            if (ctl_tx && host_wr) begin
              sh      <= host_wdata;
              sda_drv <= ~host_wdata[7];
              xmit    <= 1'b1;
              hold    <= 1'b0;
              cnt     <= '0;
              addr_ph <= 1'b0;
              phase   <= S_BITS;
            end else if (!ctl_tx && host_rd) begin
              xmit    <= 1'b0;
              hold    <= 1'b0;
              cnt     <= '0;
              addr_ph <= 1'b0;
              phase   <= S_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_low_o  = hold;
  assign sda_low_o  = sda_drv;
  assign host_rdata = sh;

endmodule

// File: rtl/i2c_hold_slave_chk.sv
module i2c_hold_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_low_o,
  input logic sda_low_o,
  input logic host_wr,
  input logic host_rd,
  input logic byte_irq
);

  a_r4_irq_with_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_o) |-> byte_irq);

  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |=> !byte_irq);

  a_r4_irq_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq |-> !scl_i);

  a_r5_release_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_low_o) |-> $past(host_wr || host_rd));

  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !$past(scl_i));

endmodule

bind i2c_hold_slave i2c_hold_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_low_o(scl_low_o),
  .sda_low_o(sda_low_o), .host_wr(host_wr), .host_rd(host_rd),
  .byte_irq(byte_irq)
);

// File: tb/test_i2c_hold_slave.sv
`timescale 1ns/1ps
module test_i2c_hold_slave;
  localparam int Q = 8;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic host_wr = 0, host_rd = 0, ctl_tx = 0, ctl_txak = 0;
  logic [7:0] host_wdata = 0;
  logic scl_i, sda_i, scl_low_o, sda_low_o, st_match, st_rw, st_rxak, byte_irq;
  logic [7:0] host_rdata;
  int checks = 0, errors = 0, irq_n = 0, viol = 0;
  logic sda_q = 0, scl_q = 1;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_i = scl_m & ~scl_low_o;
  assign sda_i = sda_m & ~sda_low_o;

  i2c_hold_slave i_i2c_hold_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ctl_tx(ctl_tx), .ctl_txak(ctl_txak),
    .st_match(st_match), .st_rw(st_rw), .st_rxak(st_rxak), .byte_irq(byte_irq)
  );

  always @(negedge clk) begin
    if (byte_irq) irq_n++;
    if (rst_n && sda_low_o !== sda_q && scl_q) viol++;
    sda_q <= sda_low_o;
    scl_q <= scl_i;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1;
    while (!scl_i) tick(1);
    tick(2*Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1; tick(Q);
    scl_m = 1;
    while (!scl_i) tick(1);
    tick(Q);
    b = sda_i;
    tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(ack);
  endtask

  task automatic byte_in(output logic [7:0] d, input logic ackb);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(ackb);
  endtask

  task automatic i2c_start;
    sda_m = 1; scl_m = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl_m = 0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 0; tick(Q);
    scl_m = 1; tick(Q);
    sda_m = 1; tick(2*Q);
  endtask

  task automatic host_access(input logic wr, input logic [7:0] d);
    host_wdata = d;
    if (wr) host_wr = 1; else host_rd = 1;
    tick(1);
    host_wr = 0; host_rd = 0;
    tick(2);
  endtask

  task automatic t_reset;
    chk("R4 reset scl_low", scl_low_o, 0);
    chk("R10 reset sda_low", sda_low_o, 0);
    chk("R1 reset match", st_match, 0);
    chk("R4 reset irq", byte_irq, 0);
  endtask

  task automatic t_master_write;
    logic ack;
    int n0;
    i2c_start;
    n0 = irq_n;
    byte_out({7'h3A, 1'b0}, ack);
    chk("R3 address ack", ack, 0);
    chk("R1 match", st_match, 1);
    chk("R1 rw write", st_rw, 0);
    chk("R4 hold after address", scl_low_o, 1);
    chk("R4 irq once", irq_n - n0, 1);
    tick(20);
    chk("R4 hold persists", scl_low_o, 1);
    host_access(1, 8'hFF);
    chk("R5 write ignored in rx", scl_low_o, 1);
    host_access(0, 0);
    chk("R5 read releases", scl_low_o, 0);
    byte_out(8'hA5, ack);
    chk("R3 data ack", ack, 0);
    chk("R7 rx data A5", host_rdata, 8'hA5);
    chk("R4 hold after data", scl_low_o, 1);
    ctl_txak = 1;
    host_access(0, 0);
    byte_out(8'h3C, ack);
    chk("R3 ack withheld", ack, 1);
    chk("R7 rx data 3C", host_rdata, 8'h3C);
    ctl_txak = 0;
    host_access(0, 0);
    n0 = irq_n;
    i2c_stop;
    chk("R9 stop clears match", st_match, 0);
    chk("R9 no hold after stop", scl_low_o, 0);
    chk("R9 sda released", sda_low_o, 0);
    chk("R9 no irq on stop", irq_n - n0, 0);
  endtask

  task automatic t_master_read;
    logic ack;
    logic [7:0] d;
    i2c_start;
    byte_out({7'h3A, 1'b1}, ack);
    chk("R3 read address ack", ack, 0);
    chk("R1 rw read", st_rw, 1);
    ctl_tx = 1;
    host_access(0, 0);
    chk("R6 read ignored in tx", scl_low_o, 1);
    host_access(1, 8'hC3);
    chk("R6 write releases", scl_low_o, 0);
    byte_in(d, 1'b0);
    chk("R6 tx byte C3", d, 8'hC3);
    chk("R8 master ack", st_rxak, 0);
    chk("R4 hold after tx", scl_low_o, 1);
    host_access(1, 8'h5A);
    byte_in(d, 1'b1);
    chk("R6 tx byte 5A", d, 8'h5A);
    chk("R8 master nack", st_rxak, 1);
    ctl_tx = 0;
    host_access(0, 0);
    chk("R5 dummy read frees bus", scl_low_o, 0);
    i2c_stop;
    chk("R9 stop after read", st_match, 0);
  endtask

  task automatic t_wrong_addr;
    logic ack;
    int n0;
    i2c_start;
    n0 = irq_n;
    byte_out({7'h15, 1'b0}, ack);
    chk("R2 no ack", ack, 1);
    chk("R2 no match", st_match, 0);
    chk("R2 no hold", scl_low_o, 0);
    chk("R2 no irq", irq_n - n0, 0);
    i2c_stop;
  endtask

  initial begin
    tick(4);
    t_reset;
    rst_n = 1;
    tick(4);
    t_master_write;
    t_master_read;
    t_wrong_addr;
    chk("R10 sda changes only with scl low", viol, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule